// File: doc/BRIEF.md
# Two-Channel Serial Sample Receiver for an Audio DAC

This block sits in front of a two-channel 16-bit audio converter. It takes a bit clock, a serial data line, a word clock and a channel select, and delivers one parallel sample register for each channel. Serial bits are sampled on rising bit-clock edges and enter a shift register that holds only the newest `SAMPLE_W` bits. A word may occupy a slot of up to 24 bit clocks. The leading padding bits fall out of the register, and the last `SAMPLE_W` bits shifted in form the sample, MSB first.

A slot counter marks the edge that carries the last bit of each slot and raises a pending flag. The copy into a channel register happens on the bit-clock edge after that one, which is normally the first bit of the next slot. If the clock stops right after the last bit, the channel registers keep their old contents until the next edge arrives. The channel select level sampled at the copy edge picks the destination register. The written register raises a one-cycle strobe. The word-clock level is registered and passed on as the integrate-enable output for the analog stage.

Top module: `dacif_serial_rx`

## Requirements
- R1: While `arst_n` is low, both sample registers read 0, both strobes are 0 and `integ_en` is 0. Asserting `arst_n` clears these outputs without waiting for a clock edge.
- R2: After `arst_n` goes high, the first two rising `bit_clk` edges do nothing. The third rising edge carries bit 0 of the first slot.
- R3: Each slot is `SLOT_BITS` edges long. The sample is the last `SAMPLE_W` bits of the slot, sent MSB first, and the leading `SLOT_BITS - SAMPLE_W` bits are discarded.
- R4: The edge that carries the final bit of a slot leaves both sample registers unchanged. The new sample appears on the next rising edge.
- R5: If `bit_clk` stops after the final bit of a slot, the sample registers hold their previous values for as long as the clock stays stopped. The new sample appears on the first edge after the clock restarts.
- R6: At the copy edge, `chan_sel` = 1 writes `left_sample` and `chan_sel` = 0 writes `right_sample`. The other channel's register is left unchanged.
- R7: The written channel's strobe is high for exactly the one cycle that follows the copy edge. The other channel's strobe stays low, and the two strobes are never high together.
- R8: `integ_en` equals the `word_clk` level sampled at the previous rising edge.
- R9: Slots follow one another with no gap. Every `SLOT_BITS` edges after the start produce exactly one copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| arst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ser_data | input | 1 | Serial sample data, MSB first |
| word_clk | input | 1 | Word clock level, forwarded as integrate enable |
| chan_sel | input | 1 | Channel select at copy edge: 1 left, 0 right |
| left_sample | output | SAMPLE_W | Left channel parallel sample |
| right_sample | output | SAMPLE_W | Right channel parallel sample |
| left_strobe | output | 1 | One-cycle pulse when the left sample is written |
| right_strobe | output | 1 | One-cycle pulse when the right sample is written |
| integ_en | output | 1 | Registered word-clock level |

## Verification
The bench builds the block with `SAMPLE_W` = 16 and `SLOT_BITS` = 20. Each slot therefore carries four padding bits that must be discarded, which exercises the path where the slot is longer than the sample. A short slot also lets dozens of back-to-back words fit in a small run. The sample sweep covers the all-zero, all-one, lone-MSB and lone-LSB patterns plus an arithmetic series, alternating channels so that each copy tests the untouched channel as well. One word is followed by a stopped clock, and a reset applied mid-stream rechecks that the slot alignment restarts correctly.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dacif_rst_sync.sv
module dacif_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/dacif_sipo.sv
module dacif_sipo #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] sreg_q;
  logic [W-1:0] sreg_d;

  always_comb begin
    sreg_d = {sreg_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign q = sreg_q;
endmodule

// File: rtl/dacif_slot_ctr.sv
module dacif_slot_ctr #(
  parameter int unsigned SLOT_BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic pend_o
);
  localparam int unsigned CW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;

  always_comb begin
    pend_d = (cnt_q == LAST);
    cnt_d  = pend_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_pend_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
endmodule

// File: rtl/dacif_chan_reg.sv
module dacif_chan_reg #(
  parameter int unsigned W  = 16,
  parameter logic        CH = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer,
  input  logic         sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         upd
);
  logic         wr_en;
  logic [W-1:0] q_q, q_d;
  logic         upd_q, upd_d;

  always_comb begin
    wr_en = xfer && (sel == CH);
    q_d   = wr_en ? d : q_q;
    upd_d = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      upd_q <= 1'b0;
    end else begin
      q_q   <= q_d;
      upd_q <= upd_d;
    end
  end

  assign q   = q_q;
  assign upd = upd_q;

  assert_hold_unwritten_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(q_q));
  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
endmodule

// File: rtl/dacif_serial_rx.sv
module dacif_serial_rx #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned SLOT_BITS = 24
) (
  input  logic                bit_clk,
  input  logic                arst_n,
  input  logic                ser_data,
  input  logic                word_clk,
  input  logic                chan_sel,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                left_strobe,
  output logic                right_strobe,
  output logic                integ_en
);
  import dacif_pkg::*;

  logic                rst_s_n;
  logic [SAMPLE_W-1:0] shift_word;
  logic                pend;
  logic [SAMPLE_W-1:0] samp [NUM_CH];
  logic [NUM_CH-1:0]   strb;
  logic                integ_q, integ_d;

  dacif_rst_sync u_rst (
    .clk     (bit_clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_s_n)
  );

  dacif_sipo #(.W(SAMPLE_W)) u_sipo (
    .clk   (bit_clk),
    .rst_n (rst_s_n),
    .din   (ser_data),
    .q     (shift_word)
  );

  dacif_slot_ctr #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk    (bit_clk),
    .rst_n  (rst_s_n),
    .pend_o (pend)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacif_chan_reg #(.W(SAMPLE_W), .CH(1'(c))) u_reg (
      .clk   (bit_clk),
      .rst_n (rst_s_n),
      .xfer  (pend),
      .sel   (chan_sel),
      .d     (shift_word),
      .q     (samp[c]),
      .upd   (strb[c])
    );
  end

  always_comb begin
    integ_d = word_clk;
  end

  always_ff @(posedge bit_clk or negedge rst_s_n) begin
    if (!rst_s_n) integ_q <= 1'b0;
    else          integ_q <= integ_d;
  end

  assign left_sample  = samp[CH_LEFT];
  assign right_sample = samp[CH_RIGHT];
  assign left_strobe  = strb[CH_LEFT];
  assign right_strobe = strb[CH_RIGHT];
  assign integ_en     = integ_q;

  assert_strobe_onehot_R7: assert property (@(posedge bit_clk) disable iff (!rst_s_n)
    $onehot0(strb));
  assert_copy_after_last_R4: assert property (@(posedge bit_clk) disable iff (!rst_s_n)
    (|strb) |-> $past(pend));
endmodule

// File: tb/tb_dacif_serial_rx.sv
module tb_dacif_serial_rx;
  localparam int SW   = 16;
  localparam int SLOT = 20;
  localparam int PAD  = SLOT - SW;

  logic          bit_clk = 1'b0;
  logic          run = 1'b1;
  logic          arst_n, ser_data, word_clk, chan_sel;
  logic [SW-1:0] left_sample, right_sample;
  logic          left_strobe, right_strobe, integ_en;

  int tests = 0;
  int fails = 0;

  logic [SW-1:0] exp_l, exp_r, prev_val;
  logic          prev_ch, have_prev;

  dacif_serial_rx #(.SAMPLE_W(SW), .SLOT_BITS(SLOT)) dut (
    .bit_clk(bit_clk), .arst_n(arst_n), .ser_data(ser_data),
    .word_clk(word_clk), .chan_sel(chan_sel),
    .left_sample(left_sample), .right_sample(right_sample),
    .left_strobe(left_strobe), .right_strobe(right_strobe),
    .integ_en(integ_en)
  );

  always begin
    #2.5;
    if (run) bit_clk = ~bit_clk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(left_sample == exp_l, req, 32'(left_sample), 32'(exp_l));
    chk(right_sample == exp_r, req, 32'(right_sample), 32'(exp_r));
  endtask

  task automatic chk_strobes(input string req, input logic el, input logic er);
    chk({left_strobe, right_strobe} == {el, er}, req,
        32'({left_strobe, right_strobe}), 32'({el, er}));
  endtask

  // one slot: PAD junk bits, then the sample MSB first
  task automatic drive_slot(input logic [SW-1:0] val, input logic ch);
    for (int i = 0; i < SLOT; i++) begin
      @(negedge bit_clk);
      if (have_prev) begin
        if (i == 0) begin
          chk_regs("R4 no copy on last-bit edge");
          chk_strobes("R4 no strobe on last-bit edge", 1'b0, 1'b0);
        end
        if (i == 1) begin
          if (prev_ch) exp_l = prev_val; else exp_r = prev_val;
          chk_regs("R3/R6 sample copied to selected channel");
          chk_strobes("R7 strobe of written channel", prev_ch, !prev_ch);
        end
        if (i == 2) chk_strobes("R7 strobe lasts one cycle", 1'b0, 1'b0);
      end
      if (i >= 1) chk(integ_en == ((i - 1) < SLOT / 2), "R8 integ_en follows word_clk",
                      32'(integ_en), 32'((i - 1) < SLOT / 2));
      chan_sel = (i == 0 && have_prev) ? prev_ch : ch;
      ser_data = (i < PAD) ? ~val[i % SW] : val[SW - 1 - (i - PAD)];
      word_clk = (i < SLOT / 2);
    end
    prev_val  = val;
    prev_ch   = ch;
    have_prev = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge bit_clk);
    arst_n = 1'b0;
    #1;
    exp_l = '0; exp_r = '0; have_prev = 1'b0;
    chk_regs("R1 async clear");
    chk_strobes("R1 strobes clear", 1'b0, 1'b0);
    chk(integ_en == 1'b0, "R1 integ_en clear", 32'(integ_en), 32'h0);
    repeat (3) @(negedge bit_clk);
    chk_regs("R1 held in reset");
    arst_n = 1'b1;
    @(posedge bit_clk);
    @(posedge bit_clk);
  endtask

  logic [SW-1:0] v;
  initial begin
    arst_n = 1'b0; ser_data = 1'b0; word_clk = 1'b0; chan_sel = 1'b0;
    exp_l = '0; exp_r = '0; prev_val = '0; prev_ch = 1'b0; have_prev = 1'b0;
    do_reset();

    // R2 / R3 / R9: corner patterns then an arithmetic sweep, back to back
    drive_slot(16'h0000, 1'b1);
    drive_slot(16'hFFFF, 1'b0);
    drive_slot(16'h8000, 1'b1);
    drive_slot(16'h0001, 1'b0);
    for (int k = 0; k < 40; k++) begin
      v = SW'(k * 40503 + 12345) ^ SW'(k << 7);
      drive_slot(v, 1'(k % 3 == 0));
    end

    // R5: stop the clock after the last bit
    drive_slot(16'hA5C3, 1'b1);
    @(negedge bit_clk);
    #1 run = 1'b0;
    chk_regs("R5 held after last bit, clock stopped");
    #200;
    chk_regs("R5 still held while stopped");
    chk_strobes("R5 no strobe while stopped", 1'b0, 1'b0);
    chan_sel = 1'b1;
    ser_data = 1'b0;
    run = 1'b1;
    @(negedge bit_clk);
    exp_l = 16'hA5C3;
    chk_regs("R5 copy on first edge after restart");
    chk_strobes("R5 strobe after restart", 1'b1, 1'b0);

    // R1/R2: reset mid-stream and realign
    do_reset();
    drive_slot(16'h1234, 1'b0);
    drive_slot(16'h5678, 1'b1);
    drive_slot(16'h9ABC, 1'b0);
    @(negedge bit_clk);
    @(negedge bit_clk);
    exp_r = 16'h9ABC;
    chk_regs("R2 alignment after second reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule